// File: doc/BRIEF.md
# TCP Segmentation Offload Engine

This block takes one large TCP send (a payload of up to 64 KB) together with one set of template header fields for Ethernet, IPv4 and TCP. It cuts the payload into frames of at most one maximum segment size (MSS) and emits each frame as a byte stream: a 54-byte header followed by that segment's payload. The header of each frame is rewritten from the template. The IP total length and IP identification change for each frame. The TCP sequence number advances by the payload bytes already emitted. The control flags are adjusted for the first and last segment, and both the IPv4 header checksum and the TCP checksum are recomputed.

The payload enters byte by byte into a buffer that holds one segment. While the bytes are written, a running ones-complement contribution of the payload is summed. When the segment is complete, the header is emitted with its finished checksums, and the buffered payload follows. A job starts with a one-cycle start pulse that latches the template, the total length and the MSS.

Top module: `tso_engine`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid_o` and `pay_ready_o` are low until a job is started.
- R2: A job of L payload bytes with effective MSS M is emitted as ceil(L/M) frames. Every frame except the last carries M payload bytes and the last carries the remainder. Each frame is 54 header bytes followed by its payload bytes in input order. `out_last_o` marks the final byte of each frame. Payload is never accepted while a frame byte is being offered.
- R3: The fixed header bytes are as follows. Bytes 0-5 are the destination MAC and bytes 6-11 the source MAC. Bytes 12-13 are 0x0800. Byte 14 is 0x45 and byte 15 is 0x00. Bytes 20-21 are 0x4000 (don't-fragment). Byte 22 is the TTL and byte 23 is 6. Bytes 26-29 are the source IP and bytes 30-33 the destination IP. Bytes 34-37 are the source and destination ports. Bytes 42-45 are the acknowledgement number. Byte 46 is 0x50, bytes 48-49 are the window, and bytes 52-53 are zero. All multi-byte fields are big-endian.
- R4: Bytes 16-17 hold 40 plus the frame's payload length. Bytes 18-19 hold the template IP identification plus the frame index (0 for the first frame), modulo 2^16.
- R5: Bytes 38-41 hold the template sequence number plus the number of payload bytes in earlier frames of the job, modulo 2^32.
- R6: Byte 47 is the template flags with bit 7 (CWR) cleared on every frame but the first, and with bit 3 (PSH) and bit 0 (FIN) cleared on every frame but the last. All other flag bits pass unchanged.
- R7: Bytes 24-25 are the inverted ones-complement sum of the ten 16-bit words of header bytes 14-33, computed with the checksum bytes taken as zero.
- R8: Bytes 50-51 are the inverted ones-complement sum of three groups of 16-bit words. The first is the IPv4 pseudo-header: the source and destination IP, protocol 6, and TCP length 20 plus the payload length. The second is header bytes 34-53 with the checksum bytes taken as zero. The third is the payload taken as big-endian 16-bit words, with an odd final byte padded with a zero low byte.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_last_o` hold and `out_valid_o` stays high. A payload byte is taken only on a cycle with `pay_valid_i` and `pay_ready_o` both high.
- R10: A start pulse is ignored while a job is in progress. A start with zero length or zero MSS leaves the block idle.
- R11: An MSS input above the `MAX_MSS` parameter is treated as `MAX_MSS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches template, length and MSS when idle |
| len_i | input | LEN_W | Total payload bytes of the job |
| mss_i | input | 16 | Maximum segment size in bytes |
| dst_mac_i | input | 48 | Destination MAC address |
| src_mac_i | input | 48 | Source MAC address |
| src_ip_i | input | 32 | Source IPv4 address |
| dst_ip_i | input | 32 | Destination IPv4 address |
| ttl_i | input | 8 | IP time to live |
| ip_id_i | input | 16 | IP identification of the first frame |
| src_port_i | input | 16 | TCP source port |
| dst_port_i | input | 16 | TCP destination port |
| seq_i | input | 32 | TCP sequence number of the first payload byte |
| ack_i | input | 32 | TCP acknowledgement number |
| flags_i | input | 8 | Template TCP flags |
| win_i | input | 16 | TCP window |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_data_i | input | 8 | Payload byte |
| pay_ready_o | output | 1 | Payload byte accepted when high with valid |
| out_valid_o | output | 1 | Frame byte valid |
| out_data_o | output | 8 | Frame byte |
| out_last_o | output | 1 | Final byte of a frame |
| out_ready_i | input | 1 | Downstream accepts frame byte |

## Verification
The engine is driven with several jobs. One job spans several segments, has a short remainder, and starts at an IP identification and sequence number that wrap. A single-segment job has an odd length. Another job is an exact multiple of the MSS, and one has an MSS above the buffer capacity. Together these separate the remainder handling, the pad byte in the TCP checksum, the first/last flag masking on one-frame and many-frame jobs, and the clamping of the MSS. Random stalls on both streams show that frame bytes hold under backpressure. A start pulse injected mid-job, a zero-length start and a zero-MSS start each show that the stream is left untouched.

// File: rtl/tso_pkg.sv
package tso_pkg;

  localparam int HDR_BYTES = 54;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_HDR, S_PAY} tso_state_e;

  typedef struct packed {
    logic [47:0] dst_mac;
    logic [47:0] src_mac;
    logic [31:0] src_ip;
    logic [31:0] dst_ip;
    logic [7:0]  ttl;
    logic [15:0] src_port;
    logic [15:0] dst_port;
    logic [31:0] ack;
    logic [7:0]  flags;
    logic [15:0] win;
  } tso_tpl_t;

  function automatic logic [15:0] csum_fin(input logic [31:0] s);
    logic [31:0] a;
    logic [31:0] b;
    a = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    b = {16'h0, a[15:0]} + {16'h0, a[31:16]};
    return ~b[15:0];
  endfunction

  function automatic logic [31:0] w32(input logic [15:0] w);
    return {16'h0, w};
  endfunction

endpackage

// File: rtl/tso_seg_buf.sv
module tso_seg_buf #(
  parameter int MAX_MSS = 1460,
  localparam int IDX_W = $clog2(MAX_MSS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic [IDX_W-1:0] cnt_o,
  output logic [31:0]      sum_o
);

  logic [7:0]       mem_q [MAX_MSS];
  logic [IDX_W-1:0] cnt_q;
  logic [31:0]      sum_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[cnt_q] <= wr_data_i;
  end

  // even byte is the high half of a 16-bit word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (wr_en_i) begin
      cnt_q <= cnt_q + 1'b1;
      sum_q <= sum_q + (cnt_q[0] ? {24'h0, wr_data_i} : {16'h0, wr_data_i, 8'h0});
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign cnt_o     = cnt_q;
  assign sum_o     = sum_q;

endmodule

// File: rtl/tso_hdr_gen.sv
module tso_hdr_gen
  import tso_pkg::*;
(
  input  tso_tpl_t    tpl_i,
  input  logic [15:0] seg_len_i,
  input  logic [15:0] ip_id_i,
  input  logic [31:0] seq_i,
  input  logic        first_i,
  input  logic        last_i,
  input  logic [31:0] pay_sum_i,
  input  logic [5:0]  idx_i,
  output logic [7:0]  byte_o
);

  logic [15:0]  ip_len, tcp_len, ip_ck, tcp_ck;
  logic [7:0]   flg;
  logic [31:0]  ip_sum, tcp_sum;
  logic [431:0] hdr_vec, hdr_sh;

  always_comb begin
    flg = tpl_i.flags;
    if (!first_i) flg[7] = 1'b0;
    if (!last_i) begin
      flg[3] = 1'b0;
      flg[0] = 1'b0;
    end
  end

  assign ip_len  = seg_len_i + 16'd40;
  assign tcp_len = seg_len_i + 16'd20;

  assign ip_sum = 32'h4500 + w32(ip_len) + w32(ip_id_i) + 32'h4000
                + w32({tpl_i.ttl, 8'h06})
                + w32(tpl_i.src_ip[31:16]) + w32(tpl_i.src_ip[15:0])
                + w32(tpl_i.dst_ip[31:16]) + w32(tpl_i.dst_ip[15:0]);

  assign tcp_sum = w32(tpl_i.src_ip[31:16]) + w32(tpl_i.src_ip[15:0])
                 + w32(tpl_i.dst_ip[31:16]) + w32(tpl_i.dst_ip[15:0])
                 + 32'h6 + w32(tcp_len)
                 + w32(tpl_i.src_port) + w32(tpl_i.dst_port)
                 + w32(seq_i[31:16]) + w32(seq_i[15:0])
                 + w32(tpl_i.ack[31:16]) + w32(tpl_i.ack[15:0])
                 + w32({8'h50, flg}) + w32(tpl_i.win) + pay_sum_i;

  assign ip_ck  = csum_fin(ip_sum);
  assign tcp_ck = csum_fin(tcp_sum);

  assign hdr_vec = {tpl_i.dst_mac, tpl_i.src_mac, 16'h0800,
                    8'h45, 8'h00, ip_len, ip_id_i, 16'h4000, tpl_i.ttl, 8'h06,
                    ip_ck, tpl_i.src_ip, tpl_i.dst_ip,
                    tpl_i.src_port, tpl_i.dst_port, seq_i, tpl_i.ack,
                    8'h50, flg, tpl_i.win, tcp_ck, 16'h0};

  assign hdr_sh = hdr_vec << {idx_i, 3'b000};
  assign byte_o = hdr_sh[431:424];

endmodule

// File: rtl/tso_engine.sv
module tso_engine
  import tso_pkg::*;
#(
  parameter int MAX_MSS = 1460,
  parameter int LEN_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [15:0]      mss_i,
  input  logic [47:0]      dst_mac_i,
  input  logic [47:0]      src_mac_i,
  input  logic [31:0]      src_ip_i,
  input  logic [31:0]      dst_ip_i,
  input  logic [7:0]       ttl_i,
  input  logic [15:0]      ip_id_i,
  input  logic [15:0]      src_port_i,
  input  logic [15:0]      dst_port_i,
  input  logic [31:0]      seq_i,
  input  logic [31:0]      ack_i,
  input  logic [7:0]       flags_i,
  input  logic [15:0]      win_i,
  input  logic             pay_valid_i,
  input  logic [7:0]       pay_data_i,
  output logic             pay_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_last_o,
  input  logic             out_ready_i
);

  localparam int          IDX_W   = $clog2(MAX_MSS + 1);
  localparam logic [15:0] MSS_CAP = 16'(MAX_MSS);

  tso_state_e       state_q;
  tso_tpl_t         tpl_q;
  logic [LEN_W-1:0] rem_q;
  logic [15:0]      mss_q, id_q, seg_len;
  logic [31:0]      seq_q;
  logic             first_q, last_seg;
  logic [5:0]       hdr_idx_q;
  logic [IDX_W-1:0] rd_idx_q, buf_cnt;
  logic [31:0]      pay_sum;
  logic [7:0]       hdr_byte, buf_byte;
  logic             take, fill_done, emit, pay_end, buf_clr, go;

  assign seg_len  = (32'(rem_q) > 32'(mss_q)) ? mss_q : 16'(rem_q);
  assign last_seg = (32'(rem_q) <= 32'(mss_q));

  assign go        = (state_q == S_IDLE) && start_i && (len_i != '0) && (mss_i != '0);
  assign take      = (state_q == S_FILL) && pay_valid_i;
  assign fill_done = take && (32'(buf_cnt) + 1 == 32'(seg_len));
  assign emit      = out_valid_o && out_ready_i;
  assign pay_end   = (state_q == S_PAY) && (32'(rd_idx_q) + 1 == 32'(seg_len));
  assign buf_clr   = go || (emit && pay_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      tpl_q     <= '0;
      rem_q     <= '0;
      mss_q     <= '0;
      id_q      <= '0;
      seq_q     <= '0;
      first_q   <= 1'b0;
      hdr_idx_q <= '0;
      rd_idx_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (go) begin
          tpl_q   <= '{dst_mac: dst_mac_i, src_mac: src_mac_i, src_ip: src_ip_i,
                       dst_ip: dst_ip_i, ttl: ttl_i, src_port: src_port_i,
                       dst_port: dst_port_i, ack: ack_i, flags: flags_i, win: win_i};
          rem_q   <= len_i;
          mss_q   <= (mss_i > MSS_CAP) ? MSS_CAP : mss_i;
          id_q    <= ip_id_i;
          seq_q   <= seq_i;
          first_q <= 1'b1;
          state_q <= S_FILL;
        end
        S_FILL: if (fill_done) begin
          hdr_idx_q <= '0;
          state_q   <= S_HDR;
        end
        S_HDR: if (emit) begin
          if (32'(hdr_idx_q) == HDR_BYTES - 1) begin
            rd_idx_q <= '0;
            state_q  <= S_PAY;
          end else begin
            hdr_idx_q <= hdr_idx_q + 1'b1;
          end
        end
        S_PAY: if (emit) begin
          if (pay_end) begin
            rem_q   <= rem_q - LEN_W'(seg_len);
            seq_q   <= seq_q + 32'(seg_len);
            id_q    <= id_q + 16'd1;
            first_q <= 1'b0;
            state_q <= last_seg ? S_IDLE : S_FILL;
          end else begin
            rd_idx_q <= rd_idx_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  tso_seg_buf #(.MAX_MSS(MAX_MSS)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .wr_en_i   (take),
    .wr_data_i (pay_data_i),
    .rd_idx_i  (rd_idx_q),
    .rd_data_o (buf_byte),
    .cnt_o     (buf_cnt),
    .sum_o     (pay_sum)
  );

  tso_hdr_gen u_hdr (
    .tpl_i     (tpl_q),
    .seg_len_i (seg_len),
    .ip_id_i   (id_q),
    .seq_i     (seq_q),
    .first_i   (first_q),
    .last_i    (last_seg),
    .pay_sum_i (pay_sum),
    .idx_i     (hdr_idx_q),
    .byte_o    (hdr_byte)
  );

  assign pay_ready_o = (state_q == S_FILL);
  assign out_valid_o = (state_q == S_HDR) || (state_q == S_PAY);
  assign out_data_o  = (state_q == S_PAY) ? buf_byte : hdr_byte;
  assign out_last_o  = pay_end;

endmodule

// File: rtl/tso_engine_chk.sv
module tso_engine_chk #(
  parameter int MAX_MSS = 1460
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pay_ready_o,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_last_o,
  input logic       out_ready_i
);

  logic [31:0] fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fcnt_q <= '0;
    else if (out_valid_o && out_ready_i) fcnt_q <= out_last_o ? '0 : fcnt_q + 1;
  end

  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o) |-> (fcnt_q >= 54 && fcnt_q <= 32'(53 + MAX_MSS)));

  // R2
  fill_emit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pay_ready_o && out_valid_o));

  // R2
  last_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o);

  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

endmodule

bind tso_engine tso_engine_chk #(.MAX_MSS(MAX_MSS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pay_ready_o (pay_ready_o),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .out_ready_i (out_ready_i)
);

// File: tb/tso_engine_bench.sv
module tso_engine_bench;

  localparam int CLK_P   = 10;
  localparam int MAX_MSS = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] len_i = '0, mss_i = '0;
  logic [47:0] dst_mac_i = 48'h0a1b2c3d4e5f, src_mac_i = 48'h665544332211;
  logic [31:0] src_ip_i = 32'hc0a80a01, dst_ip_i = 32'h0a000263;
  logic [7:0]  ttl_i = 8'd64, flags_i = '0;
  logic [15:0] ip_id_i = '0, src_port_i = 16'd49152, dst_port_i = 16'd443, win_i = 16'h7210;
  logic [31:0] seq_i = '0, ack_i = 32'h5eed0bad;
  logic        pay_valid_i = 1'b0;
  logic [7:0]  pay_data_i = '0;
  logic        pay_ready_o, out_valid_o, out_last_o;
  logic [7:0]  out_data_o;
  logic        out_ready_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] q_d[$];
  bit         q_l[$];
  string      q_r[$];

  always #(CLK_P/2) clk_i = ~clk_i;

  tso_engine #(.MAX_MSS(MAX_MSS), .LEN_W(16)) u_tso_engine (.*);

  task automatic chk(bit ok, string r, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pay_byte(int base, int i);
    return 8'((i * 37 + base * 11 + 5) & 255);
  endfunction

  function automatic logic [15:0] fin(int unsigned s);
    while ((s >> 16) != 0) s = (s & 32'hffff) + (s >> 16);
    return ~s[15:0];
  endfunction

  function automatic string tag_of(int i);
    if (i >= 16 && i <= 19) return "R4";
    if (i >= 24 && i <= 25) return "R7";
    if (i >= 38 && i <= 41) return "R5";
    if (i == 47) return "R6";
    if (i >= 50 && i <= 51) return "R8";
    return "R3";
  endfunction

  // scoreboard producer: expected frames from the requirements
  task automatic push_job(int len, int mss, logic [15:0] id, logic [31:0] seq,
                          logic [7:0] fl, int base, string ptag);
    int off = 0;
    int k = 0;
    while (off < len) begin
      logic [7:0] hb [54];
      logic [7:0] f;
      logic [15:0] il, ck;
      logic [15:0] cur_id;
      logic [31:0] cur_seq;
      int unsigned s;
      int sl;
      bit first, last;
      sl = (len - off > mss) ? mss : len - off;
      first = (k == 0);
      last = (off + sl == len);
      f = fl;
      if (!first) f[7] = 1'b0;
      if (!last) begin f[3] = 1'b0; f[0] = 1'b0; end
      il = 16'(sl + 40);
      cur_id = id + 16'(k);
      cur_seq = seq + 32'(off);
      for (int b = 0; b < 6; b++) begin
        hb[b] = dst_mac_i[47-8*b -: 8];
        hb[6+b] = src_mac_i[47-8*b -: 8];
      end
      hb[12] = 8'h08; hb[13] = 8'h00; hb[14] = 8'h45; hb[15] = 8'h00;
      hb[16] = il[15:8]; hb[17] = il[7:0];
      hb[18] = cur_id[15:8]; hb[19] = cur_id[7:0];
      hb[20] = 8'h40; hb[21] = 8'h00; hb[22] = ttl_i; hb[23] = 8'h06;
      hb[24] = 8'h00; hb[25] = 8'h00;
      for (int b = 0; b < 4; b++) begin
        hb[26+b] = src_ip_i[31-8*b -: 8];
        hb[30+b] = dst_ip_i[31-8*b -: 8];
        hb[38+b] = cur_seq[31-8*b -: 8];
        hb[42+b] = ack_i[31-8*b -: 8];
      end
      hb[34] = src_port_i[15:8]; hb[35] = src_port_i[7:0];
      hb[36] = dst_port_i[15:8]; hb[37] = dst_port_i[7:0];
      hb[46] = 8'h50; hb[47] = f;
      hb[48] = win_i[15:8]; hb[49] = win_i[7:0];
      hb[50] = 8'h00; hb[51] = 8'h00; hb[52] = 8'h00; hb[53] = 8'h00;
      s = 0;
      for (int b = 14; b < 34; b += 2) s += {hb[b], hb[b+1]};
      ck = fin(s);
      hb[24] = ck[15:8]; hb[25] = ck[7:0];
      s = src_ip_i[31:16] + src_ip_i[15:0] + dst_ip_i[31:16] + dst_ip_i[15:0] + 6 + sl + 20;
      for (int b = 34; b < 54; b += 2) s += {hb[b], hb[b+1]};
      for (int j = 0; j < sl; j++)
        s += (j % 2 == 0) ? {pay_byte(base, off + j), 8'h00} : {8'h00, pay_byte(base, off + j)};
      ck = fin(s);
      hb[50] = ck[15:8]; hb[51] = ck[7:0];
      for (int b = 0; b < 54; b++) begin
        q_d.push_back(hb[b]); q_l.push_back(1'b0); q_r.push_back(tag_of(b));
      end
      for (int j = 0; j < sl; j++) begin
        q_d.push_back(pay_byte(base, off + j));
        q_l.push_back(j == sl - 1);
        q_r.push_back(ptag);
      end
      off += sl;
      k++;
    end
  endtask

  task automatic run_job(int len, int mss, logic [15:0] id, logic [31:0] seq,
                         logic [7:0] fl, int base, string ptag, bit poke);
    int i = 0;
    bit poked = 0;
    int eff;
    eff = (mss > MAX_MSS) ? MAX_MSS : mss;
    @(negedge clk_i);
    len_i = 16'(len); mss_i = 16'(mss); ip_id_i = id; seq_i = seq; flags_i = fl;
    push_job(len, eff, id, seq, fl, base, ptag);
    start_i = 1'b1;
    while (i < len) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (poke && !poked && i == 5) begin
        // R10: start while busy must not disturb the job
        start_i = 1'b1; seq_i = 32'h0; len_i = 16'd3; mss_i = 16'd1;
        poked = 1;
      end
      pay_valid_i = ($urandom_range(0, 4) != 0);
      pay_data_i = pay_byte(base, i);
      #1;
      if (pay_valid_i && pay_ready_o) i++;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    pay_valid_i = 1'b0;
    wait (q_d.size() == 0);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic null_start(int len, int mss, string what);
    @(negedge clk_i);
    len_i = 16'(len); mss_i = 16'(mss); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(!pay_ready_o && !out_valid_o, "R10", what, {pay_ready_o, out_valid_o}, 0);
  endtask

  // scoreboard consumer
  initial begin
    bit hold_pend = 0;
    logic [7:0] hold_d = '0;
    logic hold_l = 1'b0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        out_ready_i = 1'b0;
        hold_pend = 0;
        continue;
      end
      if (hold_pend)
        chk(out_valid_o && out_data_o == hold_d && out_last_o == hold_l, "R9", "stall hold",
            {out_valid_o, out_last_o, out_data_o}, {1'b1, hold_l, hold_d});
      out_ready_i = ($urandom_range(0, 3) != 0);
      #1;
      hold_pend = out_valid_o && !out_ready_i;
      hold_d = out_data_o;
      hold_l = out_last_o;
      if (out_valid_o && out_ready_i) begin
        if (q_d.size() == 0) begin
          chk(0, "R2", "unexpected byte", out_data_o, 0);
        end else begin
          logic [7:0] ed;
          bit el;
          string er;
          ed = q_d.pop_front();
          el = q_l.pop_front();
          er = q_r.pop_front();
          chk(out_data_o == ed, er, "byte", out_data_o, ed);
          chk(out_last_o == el, "R2", "last flag", out_last_o, el);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        // R1: reset state
        chk(!out_valid_o && !pay_ready_o, "R1", "in reset", {out_valid_o, pay_ready_o}, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        chk(!out_valid_o && !pay_ready_o, "R1", "after reset", {out_valid_o, pay_ready_o}, 0);
        // multi-segment, remainder, id and seq wrap, start poke
        run_job(20, 8, 16'hffff, 32'hfffffff8, 8'h99, 1, "R2", 1'b1);
        // single odd-length segment: all flags kept, pad byte in checksum
        run_job(7, 100, 16'h1234, 32'h00001000, 8'h19, 2, "R2", 1'b0);
        null_start(0, 8, "zero length");
        null_start(9, 0, "zero mss");
        // R11: mss above capacity is clamped
        run_job(37, 40, 16'h0042, 32'h12345678, 8'h18, 3, "R11", 1'b0);
        // exact multiple of mss
        run_job(32, 16, 16'h7fff, 32'h80000000, 8'h89, 4, "R2", 1'b0);
        chk(q_d.size() == 0, "R2", "queue drained", q_d.size(), 0);
      end
      begin
        repeat (150000) @(posedge clk_i);
        chk(0, "R2", "watchdog expired", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule